// File: doc/BRIEF.md
# SPI Master Controller with Runtime Mode Select

This block is a single-channel SPI master. It drives the serial clock, the outgoing data line and one active-low select line, and it samples the incoming data line. Every transfer is full duplex. One word is shifted out while another word is shifted in, one bit in each direction per serial clock period.

Five plain configuration inputs set up a transfer:
- the clock polarity, which is the level the serial clock rests at;
- the clock phase, which picks whether the leading or the trailing edge samples;
- the bit order, least or most significant bit first;
- a short-word select that gives 7-bit instead of 8-bit words;
- a half-period divider that sets the serial clock from the system clock.

The block captures these inputs when it accepts a word. It ignores them from then until the transfer ends.

Words enter on a valid/ready stream. A word is accepted in the cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is high only while the block is idle, and this is the only back-pressure. A source may hold `tx_valid` high with stable data for as long as it needs.

The received word leaves on a valid-only stream. It has no ready signal and cannot stall. `rx_valid` pulses for one cycle, and `rx_data` keeps the word until the next transfer is accepted. After a transfer, the block waits one more half period with select high before it raises `tx_ready` again.

Top module: `spi_mode_master`

## Requirements
- R1: After reset `spi_cs_n` is 1, `tx_ready` is 1, `rx_valid` is 0 and `spi_sclk` is 0. While idle, `spi_sclk` takes the value of `cfg_cpol` one cycle later.
- R2: A word is accepted in a cycle with `tx_valid` and `tx_ready` both high. `spi_cs_n` falls at that clock edge. `tx_ready` stays 0 from acceptance until one half period after `spi_cs_n` rises.
- R3: While `spi_cs_n` is low, `spi_sclk` makes exactly two edges per word bit. When `spi_cs_n` rises, `spi_sclk` is at its idle level. While `spi_cs_n` is high, `spi_sclk` moves only in idle.
- R4: The half period H equals `cfg_half_div`, with 0 treated as 1, so the value 1 gives a serial clock at half the system clock. The first `spi_sclk` edge comes H cycles after `spi_cs_n` falls. Edges are H cycles apart. `spi_cs_n` rises H cycles after the last edge.
- R5: The edge roles follow the clock mode:
  - Leading edges, where `spi_sclk` leaves its idle level, sample `spi_miso` when `cfg_cpha`=0.
  - Trailing edges sample when `cfg_cpha`=1.
  - `spi_mosi` changes only on the other kind of edge.
  - This holds for all four combinations of `cfg_cpol` and `cfg_cpha`.
- R6: With `cfg_cpha`=0, `spi_mosi` shows the first data bit from the cycle in which `spi_cs_n` falls, before any clock edge.
- R7: With `cfg_len7`=1 a word has 7 bits. Bit 7 of `tx_data` is not sent, and bit 7 of `rx_data` is 0. With `cfg_len7`=0 a word has 8 bits.
- R8: The bit order depends on `cfg_lsb_first`. With `cfg_lsb_first`=1, bit 0 goes first. With `cfg_lsb_first`=0, the top bit of the word goes first: bit 6 for a 7-bit word, bit 7 for an 8-bit word. The received bits are placed with the same rule.
- R9: `rx_valid` is a one-cycle pulse in the first cycle in which `spi_cs_n` is high again. At that point `rx_data` holds the bits sampled from `spi_miso`.
- R10: Changes to any `cfg_*` input after a word is accepted have no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_len7 | input | 1 | 1: 7-bit words; 0: 8-bit words |
| cfg_half_div | input | DIV_W | Serial clock half period in system clocks (0 acts as 1) |
| tx_valid | input | 1 | Word offered on `tx_data` |
| tx_ready | output | 1 | Block idle and able to accept a word |
| tx_data | input | WORD_W | Word to send |
| rx_valid | output | 1 | One-cycle pulse: received word available |
| rx_data | output | WORD_W | Received word, held until the next acceptance |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low slave select |
| spi_mosi | output | 1 | Serial data out (low while not selected) |
| spi_miso | input | 1 | Serial data in |

## Verification
The bound checker watches the stream and framing rules on every cycle:
- `tx_ready` is low whenever select is low;
- an accepted word pulls select low on the next edge;
- the received-word pulse lasts one cycle and coincides with the rise of select;
- the serial clock stays frozen during the post-transfer gap;
- the idle clock follows the polarity input.

Edge roles per mode, bit order, 7-bit truncation, half-period spacing and the independence from mid-transfer configuration changes need a slave that answers on the wire. Only the bench's scenarios show these, using a behavioural slave model whose expected words come from the requirements.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_TRAIL = 2'd2,
    ST_GAP   = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
    logic short_word;
  } spi_mode_t;

endpackage

// File: rtl/spi_mm_rate.sv
// Half-period tick generator: one tick every max(half_div,1) cycles while run is high.
module spi_mm_rate #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] limit;

  assign limit = (half_div == '0) ? DIV_W'(1) : half_div;
  assign tick  = run && (cnt_q == limit - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/spi_mm_bitpos.sv
// Maps the k-th bit of a word (in transfer order) to its position in the word.
module spi_mm_bitpos #(
  parameter int WORD_W = 8,
  parameter int IDX_W  = 4,
  parameter int POS_W  = 3
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             lsb_first,
  input  logic             short_word,
  output logic [POS_W-1:0] pos
);
  logic [IDX_W-1:0] len;
  logic [IDX_W-1:0] full;

  assign len  = short_word ? IDX_W'(WORD_W - 1) : IDX_W'(WORD_W);
  assign full = lsb_first ? idx : (len - IDX_W'(1) - idx);
  assign pos  = full[POS_W-1:0];
endmodule

// File: rtl/spi_mm_seq.sv
// Transfer sequencer: select, serial clock, edge roles and bit counters.
module spi_mm_seq
  import spi_mm_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int EDGE_W = 5,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  input  spi_mode_t        mode,
  input  logic             idle_cpol,
  output logic             tx_ready,
  output logic             run,
  output logic             cs_n,
  output logic             sclk,
  output logic             sample_en,
  output logic             done,
  output logic [IDX_W-1:0] tx_idx,
  output logic [IDX_W-1:0] rx_idx
);
  seq_state_t        state_q;
  logic [EDGE_W-1:0] edge_q;
  logic [EDGE_W-1:0] edge_total;
  logic              edge_now;
  logic              lead_edge;
  logic              last_edge;
  logic              shift_en;

  assign edge_total = mode.short_word ? EDGE_W'(2 * (WORD_W - 1)) : EDGE_W'(2 * WORD_W);
  assign edge_now   = (state_q == ST_RUN) && tick;
  assign lead_edge  = ~edge_q[0];
  assign last_edge  = (edge_q == edge_total - EDGE_W'(1));
  // Leading edges sample when phase is 0, trailing edges sample when phase is 1.
  assign sample_en  = edge_now && (lead_edge ^ mode.cpha);
  // The other edges move the output bit; the very first edge finds the
  // first bit already on the line, and the final edge has nothing to move.
  assign shift_en   = edge_now && !(lead_edge ^ mode.cpha) && (edge_q != '0) && !last_edge;

  assign tx_ready = (state_q == ST_IDLE);
  assign run      = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      edge_q  <= '0;
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
      done    <= 1'b0;
      tx_idx  <= '0;
      rx_idx  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          sclk <= idle_cpol;
          if (start) begin
            state_q <= ST_RUN;
            cs_n    <= 1'b0;
            edge_q  <= '0;
            tx_idx  <= '0;
            rx_idx  <= '0;
          end
        end
        ST_RUN: begin
          if (tick) begin
            sclk <= ~sclk;
            if (sample_en) rx_idx <= rx_idx + IDX_W'(1);
            if (shift_en)  tx_idx <= tx_idx + IDX_W'(1);
            if (last_edge) state_q <= ST_TRAIL;
            else           edge_q  <= edge_q + EDGE_W'(1);
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            cs_n    <= 1'b1;
            done    <= 1'b1;
            state_q <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tick) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_mode_master.sv
module spi_mode_master
  import spi_mm_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic              cfg_len7,
  input  logic [DIV_W-1:0]  cfg_half_div,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int IDX_W  = $clog2(WORD_W) + 1;
  localparam int POS_W  = $clog2(WORD_W);
  localparam int EDGE_W = $clog2(2 * WORD_W + 1);

  spi_mode_t         mode_q;
  logic [DIV_W-1:0]  half_q;
  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] rx_q;
  logic              start;
  logic              tick;
  logic              run;
  logic              sample_en;
  logic [IDX_W-1:0]  tx_idx;
  logic [IDX_W-1:0]  rx_idx;
  logic [POS_W-1:0]  tx_pos;
  logic [POS_W-1:0]  rx_pos;
  logic [WORD_W-1:0] tx_hit;

  assign start = tx_valid && tx_ready;

  // Configuration and word are captured only at acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      half_q <= DIV_W'(1);
      tx_q   <= '0;
    end else if (start) begin
      mode_q <= '{cpol: cfg_cpol, cpha: cfg_cpha, lsb_first: cfg_lsb_first, short_word: cfg_len7};
      half_q <= cfg_half_div;
      tx_q   <= tx_data;
    end
  end

  spi_mm_rate #(.DIV_W(DIV_W)) u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .half_div (half_q),
    .tick     (tick)
  );

  spi_mm_seq #(.WORD_W(WORD_W), .EDGE_W(EDGE_W), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .tick      (tick),
    .mode      (mode_q),
    .idle_cpol (cfg_cpol),
    .tx_ready  (tx_ready),
    .run       (run),
    .cs_n      (spi_cs_n),
    .sclk      (spi_sclk),
    .sample_en (sample_en),
    .done      (rx_valid),
    .tx_idx    (tx_idx),
    .rx_idx    (rx_idx)
  );

  spi_mm_bitpos #(.WORD_W(WORD_W), .IDX_W(IDX_W), .POS_W(POS_W)) u_tx_pos (
    .idx        (tx_idx),
    .lsb_first  (mode_q.lsb_first),
    .short_word (mode_q.short_word),
    .pos        (tx_pos)
  );

  spi_mm_bitpos #(.WORD_W(WORD_W), .IDX_W(IDX_W), .POS_W(POS_W)) u_rx_pos (
    .idx        (rx_idx),
    .lsb_first  (mode_q.lsb_first),
    .short_word (mode_q.short_word),
    .pos        (rx_pos)
  );

  // Per-bit receive capture and output bit select.
  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  rx_q[b] <= 1'b0;
      else if (start)                              rx_q[b] <= 1'b0;
      else if (sample_en && (rx_pos == POS_W'(b))) rx_q[b] <= spi_miso;
    end
    assign tx_hit[b] = (tx_pos == POS_W'(b)) && tx_q[b];
  end

  assign spi_mosi = !spi_cs_n && (|tx_hit);
  assign rx_data  = rx_q;
endmodule

// File: rtl/spi_mm_checker.sv
module spi_mm_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic cfg_cpol,
  input logic rx_valid,
  input logic spi_sclk,
  input logic spi_cs_n
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assert_busy_when_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !tx_ready);

  assert_accept_selects_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !spi_cs_n);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_done_on_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (armed_q && $rose(spi_cs_n)));

  assert_clock_frozen_in_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && spi_cs_n && !tx_ready) |-> $stable(spi_sclk));

  assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && tx_ready && $past(tx_ready)) |-> (spi_sclk == $past(cfg_cpol)));
endmodule

bind spi_mode_master spi_mm_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .cfg_cpol (cfg_cpol),
  .rx_valid (rx_valid),
  .spi_sclk (spi_sclk),
  .spi_cs_n (spi_cs_n)
);

// File: tb/spi_mode_master_tb_top.sv
`timescale 1ns/1ps
module spi_mode_master_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0, cfg_len7 = 1'b0;
  logic [7:0] cfg_half_div = 8'd1;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = 8'h00;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       spi_sclk, spi_cs_n, spi_mosi;
  logic       spi_miso = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int done_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_mode_master dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
    .cfg_len7(cfg_len7), .cfg_half_div(cfg_half_div),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int bpos(input int k, input int len, input bit lsb);
    return lsb ? k : (len - 1 - k);
  endfunction

  function automatic logic [7:0] wmask(input int len);
    return (len == 7) ? 8'h7F : 8'hFF;
  endfunction

  // Expected mode of the transfer in flight (set before acceptance).
  bit         cur_cpol, cur_cpha, cur_lsb;
  int         cur_len, cur_half;
  logic [7:0] cur_tx, cur_sw, cap;
  int         s_cnt, r_cnt, edges, last_cyc;
  logic       prev_sclk = 1'b0, prev_cs = 1'b1;

  // Behavioural slave: answers on the wire using only the requirement rules.
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !spi_cs_n) begin
        chk(tx_ready == 1'b0, "R2 ready low while selected", tx_ready, 0);
        chk(spi_sclk == cur_cpol, "R3 clock idle at select", spi_sclk, cur_cpol);
        s_cnt = 0; r_cnt = 0; edges = 0; cap = 8'h00; last_cyc = cyc;
        if (!cur_cpha) begin
          chk(spi_mosi == cur_tx[bpos(0, cur_len, cur_lsb)], "R6 first bit before clock",
              spi_mosi, cur_tx[bpos(0, cur_len, cur_lsb)]);
          spi_miso <= cur_sw[bpos(0, cur_len, cur_lsb)];
          s_cnt = 1;
        end
      end else if (!spi_cs_n && (spi_sclk != prev_sclk)) begin
        bit lead;
        chk((cyc - last_cyc) == cur_half, "R4 edge spacing", cyc - last_cyc, cur_half);
        last_cyc = cyc;
        edges++;
        lead = (prev_sclk == cur_cpol);
        if (lead ^ cur_cpha) begin
          if (r_cnt < 8) cap[bpos(r_cnt, cur_len, cur_lsb)] = spi_mosi;
          r_cnt++;
        end else if (s_cnt < cur_len) begin
          spi_miso <= cur_sw[bpos(s_cnt, cur_len, cur_lsb)];
          s_cnt++;
        end
      end else if (!prev_cs && spi_cs_n) begin
        chk((cyc - last_cyc) == cur_half, "R4 release delay", cyc - last_cyc, cur_half);
        chk(edges == 2 * cur_len, "R3 edge count", edges, 2 * cur_len);
        chk(spi_sclk == cur_cpol, "R3 clock idle at release", spi_sclk, cur_cpol);
        chk(rx_valid == 1'b1, "R9 done pulse at release", rx_valid, 1);
        chk(rx_data == (cur_sw & wmask(cur_len)), "R9 R7 R8 received word",
            rx_data, cur_sw & wmask(cur_len));
        chk(cap == (cur_tx & wmask(cur_len)), "R5 R7 R8 word seen by slave",
            cap, cur_tx & wmask(cur_len));
        done_cnt++;
      end
      prev_sclk = spi_sclk;
      prev_cs   = spi_cs_n;
    end
  end

  task automatic xfer(input bit cpol, input bit cpha, input bit lsb, input bit len7,
                      input int half, input logic [7:0] txw, input logic [7:0] sw,
                      input bit disturb);
    int target;
    target = done_cnt + 1;
    @(negedge clk);
    cur_cpol = cpol; cur_cpha = cpha; cur_lsb = lsb; cur_len = len7 ? 7 : 8;
    cur_half = (half == 0) ? 1 : half; cur_tx = txw; cur_sw = sw;
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsb; cfg_len7 = len7;
    cfg_half_div = 8'(half);
    @(negedge clk);
    @(negedge clk);
    chk(spi_sclk == cpol, "R1 idle level follows polarity", spi_sclk, cpol);
    chk(tx_ready == 1'b1, "R2 ready while idle", tx_ready, 1);
    tx_valid = 1'b1; tx_data = txw;
    @(negedge clk);
    tx_valid = 1'b0; tx_data = ~txw;
    chk(spi_cs_n == 1'b0, "R2 select falls on acceptance", spi_cs_n, 0);
    if (disturb) begin
      // R10: flip every configuration input mid-transfer.
      cfg_cpol = ~cpol; cfg_cpha = ~cpha; cfg_lsb_first = ~lsb; cfg_len7 = ~len7;
      cfg_half_div = 8'(cur_half + 2);
    end
    while (done_cnt < target) @(negedge clk);
    @(negedge clk);
    chk(rx_valid == 1'b0, "R9 pulse lasts one cycle", rx_valid, 0);
    chk(rx_data == (sw & wmask(cur_len)), "R9 word held after pulse", rx_data, sw & wmask(cur_len));
    while (!tx_ready) @(negedge clk);
    cfg_cpol = cpol;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R1 reset select", spi_cs_n, 1);
    chk(tx_ready == 1'b1, "R1 reset ready", tx_ready, 1);
    chk(rx_valid == 1'b0, "R1 reset done", rx_valid, 0);
    chk(spi_sclk == 1'b0, "R1 reset clock", spi_sclk, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n == 1'b1, "R1 select after reset", spi_cs_n, 1);
    // Directed: all four clock modes at divide-by-2, 8-bit MSB first (R5, R4).
    for (int m = 0; m < 4; m++) xfer(m[1], m[0], 1'b0, 1'b0, 1, 8'hA5, 8'h3C, 1'b0);
    // Directed: LSB first and 7-bit words (R8, R7).
    xfer(1'b0, 1'b0, 1'b1, 1'b0, 2, 8'h81, 8'h7E, 1'b0);
    xfer(1'b1, 1'b1, 1'b0, 1'b1, 1, 8'hFF, 8'hFF, 1'b0);
    xfer(0, 1, 1, 1, 3, 8'hC3, 8'hD9, 1'b0);
    // Directed: divider value 0 acts as 1 (R4), config flipped mid-transfer (R10).
    xfer(1'b1, 1'b0, 1'b0, 1'b0, 0, 8'h5A, 8'h96, 1'b1);
    xfer(0, 0, 1, 1, 2, 8'h1E, 8'hE1, 1'b1);
    // Random mix.
    for (int i = 0; i < 48; i++) begin
      xfer(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), $urandom_range(0, 4), 8'($urandom), 8'($urandom),
           1'($urandom_range(0, 1)));
    end
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule